// File: doc/BRIEF.md
# SD Host Vendor Register Block

This block is the register front end of an SD/eMMC host controller. A 32-bit, word-addressed bus slave port decodes a 4 KiB window. The lower 512 bytes hold 128 vendor host registers kept locally. Everything from byte offset 0x200 upward is handed on, with the offset rebased to zero, to a separate port that talks to a standard-compatible slot controller. The slot controller's interrupt and card bus signals pass through unchanged.

Most host registers are plain storage, but three have write side effects:
- The information word at offset 0x00 is read-only. Writing bit 0 of it is a software reset: every host register returns to its power-on value, and the slot controller receives a one-cycle reset pulse.
- The PHY access word at offset 0x10 has an acknowledge bit. It is set whenever a write carries a PHY read or write request.
- The eMMC control word at offset 0x18 has a tuning trigger bit that never reads back as set.

Any access narrower than 32 bits, or not aligned to a word, gets an error response and changes nothing.

Top module: `sdhost_vendor_regs`

## Requirements
- R1: After reset, the word at offset 0x00 reads 0x00010000 and every other host word (offsets 0x004 to 0x1FC) reads 0; the slot reset output is high while the block reset is high.
- R2: A full-word write to a host offset other than 0x00, 0x10 and 0x18 stores the data unchanged, and a later read of that offset returns it.
- R3: A write to offset 0x00 never changes its value, which always reads 0x00010000.
- R4: A write to offset 0x00 with bit 0 set returns every host word to its R1 value on the next clock edge.
- R5: The software reset of R4 drives slot_rst_o high for exactly one cycle: the cycle in which the host words first show their reset values.
- R6: A write to offset 0x10 stores bit 26 as the OR of written bits 24 and 25. All other bits are stored as written.
- R7: A write to offset 0x18 always stores bit 15 as 0. All other bits are stored as written.
- R8: A valid access to a host offset is accepted in the cycle it is presented (req_ready high). rsp_valid is high in the next cycle only, with rsp_rdata holding the word for reads.
- R9: A valid access at offset 0x200 or above goes out on the slot port with slot_addr equal to the offset minus 0x200. req_ready follows slot_ready. The response comes in the cycle after the slot handshake, carrying slot_rdata and slot_err.
- R10: An access with req_size other than 2 (size codes: 0 byte, 1 halfword, 2 word, 3 reserved) or with a non-zero req_addr[1:0] is accepted at once. It gets rsp_err high, is not forwarded, and changes no host word.
- R11: irq_o equals slot_irq_i and card_o equals slot_card_i at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | 12 | Byte offset in the window |
| req_size | input | 2 | Access size code |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_rdata | output | 32 | Read data |
| rsp_err | output | 1 | Error response |
| slot_valid | output | 1 | Forwarded request present |
| slot_ready | input | 1 | Slot controller completes access |
| slot_write | output | 1 | Forwarded direction |
| slot_addr | output | 12 | Offset inside the slot register set |
| slot_wdata | output | 32 | Forwarded write data |
| slot_rdata | input | 32 | Slot read data, valid with slot_ready |
| slot_err | input | 1 | Slot error, valid with slot_ready |
| slot_rst_o | output | 1 | Reset to the slot controller |
| slot_irq_i | input | 1 | Slot controller interrupt |
| irq_o | output | 1 | Interrupt out |
| slot_card_i | input | 8 | Slot controller card bus signals |
| card_o | output | 8 | Card bus signals out |

## Verification
Two situations are hard to reach from the ports:
- The one-cycle slot reset pulse of a software reset, when the host words already hold arbitrary written data. The stimulus fills many words with random values first, then issues the reset write. It samples slot_rst_o in the response cycle and in the cycle after, and reads back every word.
- A forwarded access whose completion is stretched by a slow slot controller. The bench's slot responder holds slot_ready low for a chosen number of cycles. The bench checks the accept cycle count and the rebased address, mixed in random order with local and malformed accesses.

// File: rtl/sdv_pkg.sv
package sdv_pkg;

    localparam logic [1:0]  SIZE_WORD  = 2'd2;
    localparam logic [31:0] INFO_POR   = 32'h0001_0000;
    localparam int          IDX_INFO   = 0;
    localparam int          IDX_PHY    = 4;
    localparam int          IDX_EMMC   = 6;
    localparam int          PHY_WREQ   = 24;
    localparam int          PHY_RREQ   = 25;
    localparam int          PHY_ACK    = 26;
    localparam int          TUNE_BIT   = 15;
    localparam int          SWR_BIT    = 0;

    typedef enum logic [1:0] {
        DST_LOCAL = 2'd0,
        DST_SLOT  = 2'd1,
        DST_ERR   = 2'd2
    } dest_e;

    typedef struct packed {
        logic        valid;
        logic        err;
        logic [31:0] rdata;
    } rsp_t;

    function automatic logic [31:0] por_value(input int idx);
        return (idx == IDX_INFO) ? INFO_POR : 32'h0;
    endfunction

    // New stored value of host word idx after a full-word write.
    function automatic logic [31:0] shape_word(input int idx,
                                               input logic [31:0] wdata,
                                               input logic [31:0] old);
        logic [31:0] v;
        v = wdata;
        if (idx == IDX_INFO) begin
            v = old;
        end else if (idx == IDX_PHY) begin
            v[PHY_ACK] = wdata[PHY_WREQ] | wdata[PHY_RREQ];
        end else if (idx == IDX_EMMC) begin
            v[TUNE_BIT] = 1'b0;
        end
        return v;
    endfunction

endpackage

// File: rtl/sdv_decode.sv
module sdv_decode
    import sdv_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int SLOT_BASE = 512,
    parameter int IDX_W     = 7
) (
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    output dest_e             dest,
    output logic [IDX_W-1:0]  local_idx,
    output logic [ADDR_W-1:0] slot_off
);
    logic word_ok;
    logic in_slot;

    always_comb begin
        word_ok   = (req_size == SIZE_WORD) && (req_addr[1:0] == 2'b00);
        in_slot   = req_addr >= ADDR_W'(SLOT_BASE);
        local_idx = req_addr[2 +: IDX_W];
        slot_off  = req_addr - ADDR_W'(SLOT_BASE);
        if (!word_ok)      dest = DST_ERR;
        else if (in_slot)  dest = DST_SLOT;
        else               dest = DST_LOCAL;
    end

    // R10
    always_comb begin
        if (req_valid && (req_size != SIZE_WORD)) begin
            bad_size_chk: assert (dest == DST_ERR);
        end
    end

endmodule

// File: rtl/sdv_regfile.sv
module sdv_regfile
    import sdv_pkg::*;
#(
    parameter int WORDS = 128,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [31:0]      wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [31:0]      rd_data,
    output logic             swr_q
);
    logic [31:0] words [WORDS];
    logic        swr_now;

    assign swr_now = wr_en && (wr_idx == IDX_W'(IDX_INFO)) && wr_data[SWR_BIT];

    for (genvar i = 0; i < WORDS; i++) begin : g_word
        logic [31:0] word_q;
        always_ff @(posedge clk) begin
            if (rst || swr_now) begin
                word_q <= por_value(i);
            end else if (wr_en && (wr_idx == IDX_W'(i))) begin
                word_q <= shape_word(i, wr_data, word_q);
            end
        end
        assign words[i] = word_q;
    end

    always_ff @(posedge clk) begin
        if (rst) swr_q <= 1'b0;
        else     swr_q <= swr_now;
    end

    assign rd_data = words[rd_idx];

    if (WORDS > IDX_EMMC) begin : g_chk
        // R3
        info_const_chk: assert property (@(posedge clk) disable iff (rst)
            words[IDX_INFO] == INFO_POR);
        // R6
        phy_ack_chk: assert property (@(posedge clk) disable iff (rst)
            (wr_en && wr_idx == IDX_W'(IDX_PHY)) |=>
            (words[IDX_PHY][PHY_ACK] == ($past(wr_data[PHY_WREQ]) | $past(wr_data[PHY_RREQ]))));
        // R7
        tune_clear_chk: assert property (@(posedge clk) disable iff (rst)
            words[IDX_EMMC][TUNE_BIT] == 1'b0);
        // R4
        swr_clear_chk: assert property (@(posedge clk) disable iff (rst)
            swr_now |=> (words[IDX_PHY] == 32'h0 && words[IDX_EMMC] == 32'h0));
    end

endmodule

// File: rtl/sdv_resp.sv
module sdv_resp
    import sdv_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        accept,
    input  logic        is_write,
    input  dest_e       dest,
    input  logic [31:0] local_rdata,
    input  logic [31:0] slot_rdata,
    input  logic        slot_err,
    output rsp_t        rsp
);
    rsp_t nxt;

    always_comb begin
        nxt       = '0;
        nxt.valid = accept;
        if (accept) begin
            unique case (dest)
                DST_SLOT: begin
                    nxt.err   = slot_err;
                    nxt.rdata = is_write ? 32'h0 : slot_rdata;
                end
                DST_LOCAL: nxt.rdata = is_write ? 32'h0 : local_rdata;
                default:   nxt.err   = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rsp <= '0;
        else     rsp <= nxt;
    end

    // R8
    rsp_follow_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> rsp.valid);
    // R8
    rsp_single_chk: assert property (@(posedge clk) disable iff (rst)
        !accept |=> !rsp.valid);
    // R10
    err_resp_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && dest == DST_ERR) |=> rsp.err);

endmodule

// File: rtl/sdhost_vendor_regs.sv
module sdhost_vendor_regs
    import sdv_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int SLOT_BASE = 512,
    parameter int CARD_W    = 8,
    localparam int LOCAL_WORDS = SLOT_BASE / 4,
    localparam int IDX_W       = $clog2(LOCAL_WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic              rsp_err,
    output logic              slot_valid,
    input  logic              slot_ready,
    output logic              slot_write,
    output logic [ADDR_W-1:0] slot_addr,
    output logic [31:0]       slot_wdata,
    input  logic [31:0]       slot_rdata,
    input  logic              slot_err,
    output logic              slot_rst_o,
    input  logic              slot_irq_i,
    output logic              irq_o,
    input  logic [CARD_W-1:0] slot_card_i,
    output logic [CARD_W-1:0] card_o
);
    dest_e            dest;
    logic [IDX_W-1:0] local_idx;
    logic [31:0]      local_rdata;
    logic             accept;
    logic             swr_q;
    rsp_t             rsp;

    sdv_decode #(
        .ADDR_W    (ADDR_W),
        .SLOT_BASE (SLOT_BASE),
        .IDX_W     (IDX_W)
    ) u_decode (
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_size  (req_size),
        .dest      (dest),
        .local_idx (local_idx),
        .slot_off  (slot_addr)
    );

    assign req_ready  = (dest == DST_SLOT) ? slot_ready : 1'b1;
    assign accept     = req_valid && req_ready;
    assign slot_valid = req_valid && (dest == DST_SLOT);
    assign slot_write = req_write;
    assign slot_wdata = req_wdata;

    sdv_regfile #(
        .WORDS (LOCAL_WORDS)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (accept && req_write && dest == DST_LOCAL),
        .wr_idx  (local_idx),
        .wr_data (req_wdata),
        .rd_idx  (local_idx),
        .rd_data (local_rdata),
        .swr_q   (swr_q)
    );

    sdv_resp u_resp (
        .clk         (clk),
        .rst         (rst),
        .accept      (accept),
        .is_write    (req_write),
        .dest        (dest),
        .local_rdata (local_rdata),
        .slot_rdata  (slot_rdata),
        .slot_err    (slot_err),
        .rsp         (rsp)
    );

    assign rsp_valid  = rsp.valid;
    assign rsp_rdata  = rsp.rdata;
    assign rsp_err    = rsp.err;
    assign slot_rst_o = rst | swr_q;
    assign irq_o      = slot_irq_i;
    assign card_o     = slot_card_i;

    // R5
    swr_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && req_write && dest == DST_LOCAL && local_idx == '0 && req_wdata[SWR_BIT])
        |=> slot_rst_o);
    // R5
    swr_once_chk: assert property (@(posedge clk) disable iff (rst)
        slot_rst_o |=> !slot_rst_o);
    // R10
    err_noforward_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && dest == DST_ERR) |-> !slot_valid);
    // R9
    slot_wait_chk: assert property (@(posedge clk) disable iff (rst)
        (slot_valid && !slot_ready) |-> !req_ready);

endmodule

// File: tb/tb_sdhost_vendor_regs.sv
module tb_sdhost_vendor_regs;

    logic        clk = 0;
    logic        rst = 1;
    logic        req_valid = 0, req_write = 0;
    logic [11:0] req_addr = '0;
    logic [1:0]  req_size = 2'd2;
    logic [31:0] req_wdata = '0;
    logic        req_ready, rsp_valid, rsp_err;
    logic [31:0] rsp_rdata;
    logic        slot_valid, slot_ready, slot_write, slot_err, slot_rst_o;
    logic [11:0] slot_addr;
    logic [31:0] slot_wdata, slot_rdata;
    logic        slot_irq_i = 0, irq_o;
    logic [7:0]  slot_card_i = '0, card_o;

    int total = 0, bad = 0;
    int wait_target = 0, wcnt = 0, hs_count = 0;
    logic [11:0] hs_addr;
    logic        hs_write;
    logic [31:0] hs_wdata;
    logic [31:0] mdl [128];

    always #10 clk = ~clk;

    sdhost_vendor_regs dut (.*);

    function automatic logic [31:0] f_slot_rd(input logic [11:0] a);
        return 32'h5A00_0000 | {20'h0, a};
    endfunction

    assign slot_ready = slot_valid && (wcnt == wait_target);
    assign slot_rdata = f_slot_rd(slot_addr);
    assign slot_err   = slot_valid && (slot_addr == 12'h0FC);

    always @(posedge clk) begin
        if (slot_valid && !slot_ready) wcnt <= wcnt + 1;
        else wcnt <= 0;
        if (slot_valid && slot_ready) begin
            hs_count <= hs_count + 1;
            hs_addr  <= slot_addr;
            hs_write <= slot_write;
            hs_wdata <= slot_wdata;
        end
    end

    function automatic logic [31:0] f_shape(input int idx, input logic [31:0] w, input logic [31:0] old);
        logic [31:0] v = w;
        if (idx == 0) v = old;
        else if (idx == 4) v[26] = w[24] | w[25];
        else if (idx == 6) v[15] = 1'b0;
        return v;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 128; i++) mdl[i] = (i == 0) ? 32'h0001_0000 : 32'h0;
    endtask

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    logic sr_seen;

    task automatic acc(input logic w, input logic [11:0] a, input logic [1:0] sz,
                       input logic [31:0] d, input int wt,
                       output logic [31:0] rd, output logic e, output int cyc);
        logic accd;
        @(negedge clk);
        wait_target = wt;
        req_valid = 1; req_write = w; req_addr = a; req_size = sz; req_wdata = d;
        cyc = 0;
        forever begin
            #1;
            accd = req_ready;
            cyc++;
            @(posedge clk);
            if (accd) break;
            @(negedge clk);
        end
        @(negedge clk);
        chk(rsp_valid, "R8 rsp_valid", 32'(rsp_valid), 1);
        rd = rsp_rdata; e = rsp_err; sr_seen = slot_rst_o;
        req_valid = 0;
    endtask

    task automatic lwrite(input logic [11:0] a, input logic [31:0] d);
        logic [31:0] rd; logic e; int c;
        acc(1, a, 2'd2, d, 0, rd, e, c);
        if (a[11:2] == 0 && d[0]) model_reset();
        else mdl[a[8:2]] = f_shape(int'(a[8:2]), d, mdl[a[8:2]]);
    endtask

    task automatic lread_chk(input logic [11:0] a, input string tag);
        logic [31:0] rd; logic e; int c;
        acc(0, a, 2'd2, 0, 0, rd, e, c);
        chk(rd == mdl[a[8:2]] && !e, tag, rd, mdl[a[8:2]]);
        chk(c == 1, "R8 local accept cycles", 32'(c), 1);
    endtask

    task automatic slot_chk(input logic w, input logic [11:0] a, input logic [31:0] d, input int wt);
        logic [31:0] rd; logic e; int c; int h0;
        h0 = hs_count;
        acc(w, a, 2'd2, d, wt, rd, e, c);
        chk(c == wt + 1, "R9 accept cycles", 32'(c), 32'(wt + 1));
        chk(hs_count == h0 + 1 && hs_addr == a - 12'h200 && hs_write == w,
            "R9 slot addr", {20'h0, hs_addr}, {20'h0, a - 12'h200});
        if (w) chk(hs_wdata == d, "R9 slot wdata", hs_wdata, d);
        else chk(rd == f_slot_rd(a - 12'h200), "R9 slot rdata", rd, f_slot_rd(a - 12'h200));
        chk(e == (a == 12'h2FC), "R9 slot err", 32'(e), 32'(a == 12'h2FC));
    endtask

    task automatic bad_chk(input logic w, input logic [11:0] a, input logic [1:0] sz, input logic [31:0] d);
        logic [31:0] rd; logic e; int c; int h0;
        h0 = hs_count;
        acc(w, a, sz, d, 0, rd, e, c);
        chk(e && c == 1, "R10 error response", 32'(e), 1);
        chk(hs_count == h0, "R10 not forwarded", 32'(hs_count), 32'(h0));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] rd; logic e; int c;
        void'($urandom(32'd1234));
        model_reset();
        repeat (3) @(negedge clk);
        chk(slot_rst_o, "R1/R5 slot reset during rst", 32'(slot_rst_o), 1);
        rst = 0;
        @(negedge clk);
        chk(!slot_rst_o, "R5 slot reset released", 32'(slot_rst_o), 0);

        // R1: reset values
        for (int i = 0; i < 128; i++) lread_chk(12'(i * 4), "R1 reset value");

        // R3: info word read-only
        lwrite(12'h000, 32'hFFFF_FFFE);
        lread_chk(12'h000, "R3 info unchanged");

        // R6: acknowledge
        lwrite(12'h010, 32'h0100_0055); lread_chk(12'h010, "R6 ack on write req");
        lwrite(12'h010, 32'h0200_0000); lread_chk(12'h010, "R6 ack on read req");
        lwrite(12'h010, 32'h0400_1234); lread_chk(12'h010, "R6 ack cleared");
        chk(mdl[4] == 32'h0000_1234, "R6 model sanity", mdl[4], 32'h0000_1234);

        // R7: tune bit
        lwrite(12'h018, 32'hFFFF_FFFF); lread_chk(12'h018, "R7 tune cleared");
        chk(mdl[6] == 32'hFFFF_7FFF, "R7 model sanity", mdl[6], 32'hFFFF_7FFF);

        // R2: plain storage, including last word
        lwrite(12'h1FC, 32'hDEAD_BEEF); lread_chk(12'h1FC, "R2 last word");
        lwrite(12'h004, 32'h1357_9BDF); lread_chk(12'h004, "R2 plain word");

        // R10: malformed accesses
        bad_chk(1, 12'h004, 2'd1, 32'h0);
        bad_chk(1, 12'h00A, 2'd2, 32'h0);
        bad_chk(1, 12'h000, 2'd0, 32'h1);
        bad_chk(0, 12'h300, 2'd0, 32'h0);
        lread_chk(12'h004, "R10 no state change");
        lread_chk(12'h000, "R10 no reset from bad write");

        // R9: forwarding
        slot_chk(0, 12'h200, 0, 0);
        slot_chk(1, 12'hFFC, 32'hA1B2_C3D4, 3);
        slot_chk(0, 12'h2FC, 0, 2);

        // R11: passthrough
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            slot_irq_i = 1'($urandom); slot_card_i = 8'($urandom);
            #1;
            chk(irq_o == slot_irq_i && card_o == slot_card_i, "R11 passthrough",
                {23'h0, irq_o, card_o}, {23'h0, slot_irq_i, slot_card_i});
        end

        // Random mix
        for (int n = 0; n < 400; n++) begin
            int k = int'($urandom_range(0, 9));
            logic [11:0] a = {3'b000, 7'($urandom), 2'b00};
            logic [31:0] d = $urandom;
            if (a == 12'h000) d[0] = 1'b0;
            if (k < 4) lwrite(a, d);
            else if (k < 7) lread_chk(a, "R2/R6/R7 random readback");
            else if (k < 9) slot_chk(1'($urandom), {1'b0, 11'($urandom_range(512, 2047)), 2'b00} & 12'hFFC
                                     | 12'h200, $urandom, int'($urandom_range(0, 4)));
            else bad_chk(1'($urandom), a | 12'(1 + $urandom_range(0, 2)), 2'd2, d);
        end

        // R4/R5: software reset clears everything
        for (int i = 1; i < 128; i++) lwrite(12'(i * 4), $urandom | 32'h1);
        acc(1, 12'h000, 2'd2, 32'h0000_0001, 0, rd, e, c);
        model_reset();
        chk(sr_seen, "R5 slot reset pulse", 32'(sr_seen), 1);
        @(negedge clk);
        chk(!slot_rst_o, "R5 pulse one cycle", 32'(slot_rst_o), 0);
        for (int i = 0; i < 128; i++) lread_chk(12'(i * 4), "R4 reinit value");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule